// File: doc/BRIEF.md
# Wall Clock Time-of-Day Counter

This block keeps the time of day for a network node that is being slaved to a remote time source. It holds a 48-bit seconds count and a 30-bit nanoseconds count, clocked by a 25 MHz reference. On every tick the nanoseconds advance by a programmable whole-nanosecond step plus the carry of a 24-bit sub-nanosecond accumulator. The sub-nanosecond part lets an external servo trim the frequency in fine steps. When the nanoseconds pass one billion, the seconds count moves on.

Software reaches the counter through a simple write port of eight word addresses. Through it, software can:
- stage a complete time and commit it in a single edge;
- apply a signed step correction of up to just under one second;
- change the whole and fractional step;
- select the capture and pulse options.

A start-of-frame strobe from the receive path latches the current time in either a 64-bit or a compact 32-bit layout. A pulse-per-second output rises each time the seconds count advances by counting. It stays high for a programmable number of ticks.

Top module: `tod_clock`

## Requirements
- R1: While the active-low reset is asserted, and on leaving it, the time is 0 s / 0 ns, the step is 40 ns, the fraction is 0, capture and pulse output are disabled, and `cap_valid_o` and `pps_o` are low.
- R2: On each clock edge with no write to address 2 or 3, the nanoseconds advance by the step plus the fraction carry. Without a write, the time never moves backwards.
- R3: Address 5 bits [23:0] set the fraction. The fraction is added each tick into a 24-bit accumulator, and each carry out of the accumulator adds one extra nanosecond on that tick. For example, 0x800000 adds 4 ns over 8 ticks.
- R4: The nanoseconds stay below 1,000,000,000. A wrap carries into the full 48-bit seconds count, including a carry from bit 31 into bit 32.
- R5: Address 0 bits [29:0] stage the nanoseconds and address 1 bits [15:0] stage seconds bits [47:32]; neither changes the running time. A write to address 2 loads seconds {staged, data[31:0]} and the staged nanoseconds at that edge, with no increment on that tick.
- R6: A write to address 3 applies a step on that edge, in addition to the tick's increment. Bit 31 selects the direction (1 = subtract) and bits [29:0] give the magnitude in nanoseconds, below 1e9. The result is normalised with a borrow of one second or a carry of up to two seconds.
- R7: With capture enabled (address 6 bit 0), an `sfd_i` high at an edge makes `cap_valid_o` high for the next cycle. `cap_ts_o` then holds the time that was present at that edge.
- R8: Address 6 bit 1 = 1 selects the layout {seconds[31:0], 2'b0, ns[29:0]}. When the bit is 0, the layout is {32'b0, seconds[1:0], ns[29:0]}.
- R9: With capture disabled, `sfd_i` raises no `cap_valid_o`, and `cap_ts_o` keeps its previous value.
- R10: With the pulse enabled (address 6 bit 2), a seconds advance caused by a nanosecond wrap drives `pps_o` high from the next cycle, for the number of cycles written to address 7 bits [15:0]. With the pulse disabled, `pps_o` stays low.
- R11: Address 4 bits [7:0] set the whole step. The new step applies from the tick after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 25 MHz reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Register write data |
| sfd_i | input | 1 | Receive start-of-frame strobe |
| tod_sec_o | output | 48 | Current seconds |
| tod_ns_o | output | 30 | Current nanoseconds |
| cap_valid_o | output | 1 | Captured timestamp valid, one cycle |
| cap_ts_o | output | 64 | Captured timestamp |
| pps_o | output | 1 | Pulse-per-second output |

## Verification
The bench builds the block with its default parameters: 48-bit seconds, 30-bit nanoseconds, an 8-bit step, a 24-bit fraction and a 16-bit pulse width. Because a wrap at these widths is a billion nanoseconds away, the bench loads times a few ticks below the wrap, and just below a 32-bit seconds boundary. This brings the nanosecond carry, the carry into the upper seconds bits, the two-second carry of a large step and the pulse start within a handful of cycles. A pulse width of 3 keeps the whole pulse window observable.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int unsigned NS_PER_SEC = 1_000_000_000;
    localparam int unsigned ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_NS_STAGE     = 3'd0,
        REG_SECHI_STAGE  = 3'd1,
        REG_SECLO_COMMIT = 3'd2,
        REG_ADJUST       = 3'd3,
        REG_INC_NS       = 3'd4,
        REG_INC_FRAC     = 3'd5,
        REG_CTRL         = 3'd6,
        REG_PPS_WIDTH    = 3'd7
    } reg_addr_e;

    localparam int unsigned CTRL_CAP_EN = 0;
    localparam int unsigned CTRL_FMT64  = 1;
    localparam int unsigned CTRL_PPS_EN = 2;

endpackage

// File: rtl/tod_frac.sv
module tod_frac #(
    parameter int unsigned FRAC_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FRAC_W-1:0] frac_inc_i,
    output logic              carry_o
);

    logic [FRAC_W-1:0] acc_d, acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, frac_inc_i};
        acc_d   = sum[FRAC_W-1:0];
        carry_o = sum[FRAC_W];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) acc_q <= '0;
        else         acc_q <= acc_d;
    end

endmodule

// File: rtl/tod_time.sv
module tod_time
    import tod_pkg::*;
#(
    parameter int unsigned SEC_W = 48,
    parameter int unsigned NS_W  = 30,
    parameter int unsigned INC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [INC_W-1:0] inc_ns_i,
    input  logic             extra_ns_i,
    input  logic             load_en_i,
    input  logic [SEC_W-1:0] load_sec_i,
    input  logic [NS_W-1:0]  load_ns_i,
    input  logic             adj_en_i,
    input  logic             adj_neg_i,
    input  logic [NS_W-1:0]  adj_mag_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [NS_W-1:0]  ns_o,
    output logic             sec_up_o
);

    localparam int unsigned TW = NS_W + 3;
    localparam logic signed [TW-1:0] ROLL1 = TW'(NS_PER_SEC);
    localparam logic signed [TW-1:0] ROLL2 = TW'(64'(NS_PER_SEC) * 2);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } time_t;

    time_t st_d, st_q;
    logic signed [TW-1:0] sum_base, sum_all;

    always_comb begin
        st_d     = st_q;
        sec_up_o = 1'b0;
        sum_base = $signed(TW'(st_q.ns)) + $signed(TW'(inc_ns_i))
                 + $signed(TW'(extra_ns_i));
        sum_all  = sum_base;
        if (adj_en_i) begin
            if (adj_neg_i) sum_all = sum_base - $signed(TW'(adj_mag_i));
            else           sum_all = sum_base + $signed(TW'(adj_mag_i));
        end
        if (load_en_i) begin
            st_d.sec = load_sec_i;
            st_d.ns  = load_ns_i;
        end else if (sum_all >= ROLL2) begin
            st_d.ns  = NS_W'(sum_all - ROLL2);
            st_d.sec = st_q.sec + SEC_W'(2);
            sec_up_o = 1'b1;
        end else if (sum_all >= ROLL1) begin
            st_d.ns  = NS_W'(sum_all - ROLL1);
            st_d.sec = st_q.sec + SEC_W'(1);
            sec_up_o = 1'b1;
        end else if (sum_all < 0) begin
            st_d.ns  = NS_W'(sum_all + ROLL1);
            st_d.sec = st_q.sec - SEC_W'(1);
        end else begin
            st_d.ns  = NS_W'(sum_all);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sec_o = st_q.sec;
    assign ns_o  = st_q.ns;

endmodule

// File: rtl/tod_capture.sv
module tod_capture #(
    parameter int unsigned NS_W = 30
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sfd_i,
    input  logic            en_i,
    input  logic            fmt64_i,
    input  logic [31:0]     sec_lo_i,
    input  logic [NS_W-1:0] ns_i,
    output logic            valid_o,
    output logic [63:0]     ts_o
);

    localparam int unsigned HALF_W = 32;
    localparam int unsigned SEC_IN_LO = HALF_W - NS_W;

    typedef struct packed {
        logic        valid;
        logic [63:0] ts;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = sfd_i && en_i;
        if (sfd_i && en_i) begin
            if (fmt64_i) cap_d.ts = {sec_lo_i, HALF_W'(ns_i)};
            else         cap_d.ts = {{HALF_W{1'b0}}, sec_lo_i[SEC_IN_LO-1:0], ns_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign valid_o = cap_q.valid;
    assign ts_o    = cap_q.ts;

endmodule

// File: rtl/tod_pps.sv
module tod_pps #(
    parameter int unsigned PPS_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [PPS_W-1:0] width_i,
    input  logic             sec_up_i,
    output logic             pps_o
);

    logic [PPS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i)                cnt_d = '0;
        else if (sec_up_i)        cnt_d = width_i;
        else if (cnt_q != '0)     cnt_d = cnt_q - PPS_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign pps_o = (cnt_q != '0);

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int unsigned SEC_W     = 48,
    parameter int unsigned NS_W      = 30,
    parameter int unsigned INC_W     = 8,
    parameter int unsigned FRAC_W    = 24,
    parameter int unsigned PPS_W     = 16,
    parameter int unsigned INC_RESET = 40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic              sfd_i,
    output logic [SEC_W-1:0]  tod_sec_o,
    output logic [NS_W-1:0]   tod_ns_o,
    output logic              cap_valid_o,
    output logic [63:0]       cap_ts_o,
    output logic              pps_o
);

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned SEC_HI_W = SEC_W - DATA_W;

    typedef struct packed {
        logic [NS_W-1:0]     ns_stage;
        logic [SEC_HI_W-1:0] sechi_stage;
        logic [INC_W-1:0]    inc_ns;
        logic [FRAC_W-1:0]   inc_frac;
        logic                cap_en;
        logic                cap_fmt64;
        logic                pps_en;
        logic [PPS_W-1:0]    pps_width;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic load_en, adj_en, extra_ns, sec_up;

    always_comb begin
        cfg_d   = cfg_q;
        load_en = 1'b0;
        adj_en  = 1'b0;
        if (wr_en_i) begin
            case (wr_addr_i)
                REG_NS_STAGE:     cfg_d.ns_stage    = wr_data_i[NS_W-1:0];
                REG_SECHI_STAGE:  cfg_d.sechi_stage = wr_data_i[SEC_HI_W-1:0];
                REG_SECLO_COMMIT: load_en           = 1'b1;
                REG_ADJUST:       adj_en            = 1'b1;
                REG_INC_NS:       cfg_d.inc_ns      = wr_data_i[INC_W-1:0];
                REG_INC_FRAC:     cfg_d.inc_frac    = wr_data_i[FRAC_W-1:0];
                REG_CTRL: begin
                    cfg_d.cap_en    = wr_data_i[CTRL_CAP_EN];
                    cfg_d.cap_fmt64 = wr_data_i[CTRL_FMT64];
                    cfg_d.pps_en    = wr_data_i[CTRL_PPS_EN];
                end
                REG_PPS_WIDTH:    cfg_d.pps_width   = wr_data_i[PPS_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q        <= '0;
            cfg_q.inc_ns <= INC_W'(INC_RESET);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    tod_frac #(.FRAC_W(FRAC_W)) u_frac (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .frac_inc_i (cfg_q.inc_frac),
        .carry_o    (extra_ns)
    );

    tod_time #(.SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W)) u_time (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .inc_ns_i   (cfg_q.inc_ns),
        .extra_ns_i (extra_ns),
        .load_en_i  (load_en),
        .load_sec_i ({cfg_q.sechi_stage, wr_data_i}),
        .load_ns_i  (cfg_q.ns_stage),
        .adj_en_i   (adj_en),
        .adj_neg_i  (wr_data_i[DATA_W-1]),
        .adj_mag_i  (wr_data_i[NS_W-1:0]),
        .sec_o      (tod_sec_o),
        .ns_o       (tod_ns_o),
        .sec_up_o   (sec_up)
    );

    tod_capture #(.NS_W(NS_W)) u_cap (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sfd_i    (sfd_i),
        .en_i     (cfg_q.cap_en),
        .fmt64_i  (cfg_q.cap_fmt64),
        .sec_lo_i (tod_sec_o[DATA_W-1:0]),
        .ns_i     (tod_ns_o),
        .valid_o  (cap_valid_o),
        .ts_o     (cap_ts_o)
    );

    tod_pps #(.PPS_W(PPS_W)) u_pps (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (cfg_q.pps_en),
        .width_i  (cfg_q.pps_width),
        .sec_up_i (sec_up),
        .pps_o    (pps_o)
    );

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter int unsigned SEC_W = 48,
    parameter int unsigned NS_W  = 30
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic              sfd_i,
    input logic [NS_W-1:0]   ns_stage_i,
    input logic              pps_en_i,
    input logic [SEC_W-1:0]  sec_i,
    input logic [NS_W-1:0]   ns_i,
    input logic              cap_valid_i,
    input logic              pps_i
);

    localparam logic [NS_W-1:0] ROLL_NS = NS_W'(NS_PER_SEC);

    a_r4_ns_below_roll: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ns_i < ROLL_NS);

    a_r2_no_backstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(wr_en_i) && sec_i == $past(sec_i)) |-> ns_i >= $past(ns_i));

    a_r5_commit_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_en_i && wr_addr_i == REG_SECLO_COMMIT) |-> ns_i == $past(ns_stage_i));

    a_r7_valid_after_sfd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_valid_i |-> $past(sfd_i));

    a_r10_pps_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pps_en_i |=> !pps_i);

    a_r10_pps_on_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pps_i) |-> sec_i != $past(sec_i));

endmodule

bind tod_clock tod_clock_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .sfd_i       (sfd_i),
    .ns_stage_i  (cfg_q.ns_stage),
    .pps_en_i    (cfg_q.pps_en),
    .sec_i       (tod_sec_o),
    .ns_i        (tod_ns_o),
    .cap_valid_i (cap_valid_o),
    .pps_i       (pps_o)
);

// File: tb/tod_clock_tb.sv
`timescale 1ns/1ps
module tod_clock_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        sfd = 1'b0;
    logic [47:0] sec;
    logic [29:0] ns;
    logic        cap_valid;
    logic [63:0] cap_ts;
    logic        pps;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tod_clock u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .sfd_i(sfd), .tod_sec_o(sec), .tod_ns_o(ns),
        .cap_valid_o(cap_valid), .cap_ts_o(cap_ts), .pps_o(pps)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_time(input logic [47:0] s, input logic [29:0] n);
        wr(3'd0, 32'(n));
        wr(3'd1, 32'(s[47:32]));
        wr(3'd2, s[31:0]);
    endtask

    task automatic t_reset;
        tick(2);
        check("R1", "sec in reset", 64'(sec), 64'd0);
        check("R1", "ns in reset", 64'(ns), 64'd0);
        check("R1", "pps in reset", 64'(pps), 64'd0);
        check("R1", "valid in reset", 64'(cap_valid), 64'd0);
        rst_n = 1'b1;
        tick(1);
        check("R1", "default step 40", 64'(ns), 64'd40);
        tick(4);
        check("R2", "five ticks", 64'(ns), 64'd200);
    endtask

    task automatic t_load;
        logic [47:0] s0;
        logic [29:0] n0;
        wr(3'd0, 32'd1000);
        s0 = sec; n0 = ns;
        wr(3'd1, 32'h0001);
        check("R5", "stage keeps sec", 64'(sec), 64'(s0));
        check("R5", "stage keeps counting", 64'(ns), 64'(n0 + 30'd40));
        wr(3'd2, 32'd5);
        check("R5", "commit sec", 64'(sec), 64'h0001_0000_0005);
        check("R5", "commit ns", 64'(ns), 64'd1000);
        tick(10);
        check("R2", "ten ticks after load", 64'(ns), 64'd1400);
    endtask

    task automatic t_inc;
        logic [29:0] n0;
        n0 = ns;
        wr(3'd4, 32'd10);
        check("R11", "old step on write edge", 64'(ns), 64'(n0 + 30'd40));
        n0 = ns;
        tick(5);
        check("R11", "new step 10", 64'(ns), 64'(n0 + 30'd50));
        wr(3'd4, 32'd40);
    endtask

    task automatic t_frac;
        logic [29:0] n0;
        wr(3'd5, 32'h0080_0000);
        n0 = ns;
        tick(8);
        check("R3", "half fraction over 8 ticks", 64'(ns), 64'(n0 + 30'd324));
        wr(3'd5, 32'd0);
    endtask

    task automatic t_wrap;
        load_time(48'h0000_FFFF_FFFF, 30'd999_999_980);
        tick(1);
        check("R4", "ns after wrap", 64'(ns), 64'd20);
        check("R4", "sec carry into upper", 64'(sec), 64'h0001_0000_0000);
    endtask

    task automatic t_adj;
        load_time(48'd10, 30'd100);
        wr(3'd3, {2'b10, 30'd500});
        check("R6", "borrow ns", 64'(ns), 64'd999_999_640);
        check("R6", "borrow sec", 64'(sec), 64'd9);
        load_time(48'd20, 30'd999_999_000);
        wr(3'd3, {2'b00, 30'd2000});
        check("R6", "carry ns", 64'(ns), 64'd1040);
        check("R6", "carry sec", 64'(sec), 64'd21);
        load_time(48'd30, 30'd999_999_990);
        wr(3'd3, {2'b00, 30'd999_999_999});
        check("R6", "double carry ns", 64'(ns), 64'd29);
        check("R6", "double carry sec", 64'(sec), 64'd32);
        load_time(48'd40, 30'd5000);
        wr(3'd3, {2'b10, 30'd3});
        check("R6", "small step back ns", 64'(ns), 64'd5037);
        check("R6", "small step back sec", 64'(sec), 64'd40);
    endtask

    task automatic t_capture;
        logic [63:0] exp;
        logic [63:0] held;
        wr(3'd6, 32'h3);
        load_time(48'h0000_8765_4321, 30'd5000);
        exp = {sec[31:0], 32'(ns)};
        sfd = 1'b1; tick(1); sfd = 1'b0;
        check("R7", "valid after sfd", 64'(cap_valid), 64'd1);
        check("R8", "64-bit layout", cap_ts, exp);
        tick(1);
        check("R7", "valid one cycle", 64'(cap_valid), 64'd0);
        wr(3'd6, 32'h1);
        exp = {32'd0, sec[1:0], ns};
        sfd = 1'b1; tick(1); sfd = 1'b0;
        check("R7", "valid 32-bit", 64'(cap_valid), 64'd1);
        check("R8", "32-bit layout", cap_ts, exp);
        wr(3'd6, 32'h0);
        held = cap_ts;
        sfd = 1'b1; tick(1); sfd = 1'b0;
        check("R9", "no valid when off", 64'(cap_valid), 64'd0);
        check("R9", "ts held when off", cap_ts, held);
    endtask

    task automatic t_pps;
        wr(3'd7, 32'd3);
        wr(3'd6, 32'h4);
        load_time(48'd7, 30'd999_999_900);
        tick(2);
        check("R10", "low before wrap", 64'(pps), 64'd0);
        tick(1);
        check("R10", "high after wrap", 64'(pps), 64'd1);
        check("R4", "sec at pps", 64'(sec), 64'd8);
        tick(1);
        check("R10", "high cycle 2", 64'(pps), 64'd1);
        tick(1);
        check("R10", "high cycle 3", 64'(pps), 64'd1);
        tick(1);
        check("R10", "low after width", 64'(pps), 64'd0);
        wr(3'd6, 32'h0);
        load_time(48'd7, 30'd999_999_900);
        tick(3);
        check("R10", "disabled stays low", 64'(pps), 64'd0);
        tick(1);
        check("R10", "disabled stays low later", 64'(pps), 64'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_load;
        t_inc;
        t_frac;
        t_wrap;
        t_adj;
        t_capture;
        t_pps;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule